// File: doc/BRIEF.md
# DMA Command Responder for a Storage Endpoint

This block is the command engine on the device side of a serial storage link. It takes whole frames from the transport side as a stream of 32-bit dwords marked with start and end flags. It services 48-bit-address DMA write and DMA read commands against a small on-chip sector store. It answers with its own frames on an outgoing dword stream: a DMA-activate frame to invite write data, data frames carrying read data, and a register status frame that closes a command.

A write runs as a dialogue. The command opens a sector window. Each data frame that arrives is stored at the current write sector, and the block answers either with a new DMA-activate or, once the window is full, with the status frame. A read runs by itself. The window is cut into data frames of at most `MAX_FRAME_DW` payload dwords, which go out back to back and are followed by the status frame. While the block is answering, its input is held off, so no new frame can arrive before the status frame of the previous command has left.

Top module: `dma_cmd_responder`

## Requirements
- R1: `rx_ready` is low in every cycle in which `tx_valid` is high, and in the cycle right after any accepted frame end (`rx_valid && rx_ready && rx_eof`). In all other cycles it is high.
- R2: The frame type is bits [7:0] of the first dword. Type 0x27 (register, host to device) and type 0x46 (data) are handled. A frame of any other type produces no output frame and leaves the sector store unchanged.
- R3: A type 0x27 frame whose command byte, bits [23:16] of dword 0, is 0x35 starts a write. Start sector = dword 1 + (dword 2 [15:0] << 32), modulo 2^48. End sector = start + dword 3 [15:0]. The reply is one DMA-activate frame: the single dword 0x00000039, with start and end flags both set.
- R4: A type 0x27 frame with any command byte other than 0x35 or 0x25 produces no output frame.
- R5: For a data frame, payload dword i (the i-th dword after the header) is stored at store address (write_sector × SECTOR_DW + i) mod (SECTOR_DW × RAM_SECTORS). The write sector then advances by floor(payload dwords / SECTOR_DW).
- R6: After a data frame, the reply is a status frame if the advanced write sector equals the end sector, and a DMA-activate frame otherwise. This includes the case where the write window was opened with a count of 0.
- R7: A status frame is 5 dwords. The first dword is 0x00500034: type 0x34, status 0x50 in bits [23:16]. The other four dwords are zero. The start flag is set on the first dword and the end flag on the last.
- R8: A type 0x27 frame with command byte 0x25 starts a read over the same window as in R3. While sectors remain, the block sends a data frame: the header 0x00000046, then min(remaining, MAX_FRAME_DW / SECTOR_DW) sectors of stored dwords in ascending address order (mod store size), with the end flag on the last dword. After the last data frame it sends one status frame. A count of 0 gives only the status frame.
- R9: Every output frame is contiguous: `tx_valid` stays high from the start beat through the end beat. The first beat of a reply appears in the second cycle after the triggering frame's end beat is accepted.
- R10: After reset, `tx_valid` is low, `rx_ready` is high, and the write sector is 0, so a data frame arriving before any command is stored at sector 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Incoming dword valid |
| rx_sof | input | 1 | Incoming dword is the first of its frame |
| rx_eof | input | 1 | Incoming dword is the last of its frame |
| rx_data | input | 32 | Incoming dword |
| rx_ready | output | 1 | Block accepts an incoming dword this cycle |
| tx_valid | output | 1 | Outgoing dword valid |
| tx_sof | output | 1 | Outgoing dword is the first of its frame |
| tx_eof | output | 1 | Outgoing dword is the last of its frame |
| tx_data | output | 32 | Outgoing dword |

## Verification
Some properties are checked on every cycle: the input hold-off while a reply is being sent and after each frame end, contiguous output frames, and the type of the first reply beat that follows each decoded write command, read command or data frame. Other behaviour only the bench scenarios can show, because it depends on stored contents and sector arithmetic: which dwords land at which store address, how a read window is split into frames, wrap-around of the store, and when the write window is judged complete. The bench checks these against its own model of the store.

// File: rtl/dma_resp_pkg.sv
package dma_resp_pkg;
   localparam int LBA_W = 48;
   localparam int CNT_W = 16;

   // frame type codes (low byte of the first dword)
   localparam logic [7:0] FT_REG_H2D = 8'h27;
   localparam logic [7:0] FT_REG_D2H = 8'h34;
   localparam logic [7:0] FT_DMA_ACT = 8'h39;
   localparam logic [7:0] FT_DATA    = 8'h46;

   // command byte codes
   localparam logic [7:0] CMD_WR_EXT = 8'h35;
   localparam logic [7:0] CMD_RD_EXT = 8'h25;

   localparam logic [7:0] STATUS_OK  = 8'h50;
   localparam int         STAT_DW    = 5;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_ACT,
      TX_STAT,
      TX_DHDR,
      TX_DPAY
   } tx_state_e;
endpackage

// File: rtl/dma_rx_decode.sv
module dma_rx_decode
   import dma_resp_pkg::*;
#(
   parameter int SECTOR_DW   = 128,
   parameter int RAM_SECTORS = 8,
   parameter int BEAT_W      = 12,
   localparam int SW = $clog2(SECTOR_DW),
   localparam int AW = $clog2(SECTOR_DW * RAM_SECTORS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic [31:0]       rx_data,
   input  logic              rx_ready,
   input  logic [LBA_W-1:0]  wr_sector,
   output logic              ram_we,
   output logic [AW-1:0]     ram_waddr,
   output logic [31:0]       ram_wdata,
   output logic              evt_wr_cmd,
   output logic              evt_rd_cmd,
   output logic              evt_data,
   output logic              evt_pend,
   output logic [LBA_W-1:0]  evt_lba,
   output logic [CNT_W-1:0]  evt_cnt,
   output logic [BEAT_W-1:0] evt_pay
);
   logic              acc;
   logic [BEAT_W-1:0] beat_q, beat;
   logic [7:0]        ftype_q, fcmd_q, ftype, fcmd;
   logic [31:0]       lba_lo_q;
   logic [15:0]       lba_hi_q;
   logic [CNT_W-1:0]  cnt_q;

   assign acc = rx_valid & rx_ready;

   always_comb begin
      beat  = rx_sof ? '0 : beat_q;
      ftype = rx_sof ? rx_data[7:0]   : ftype_q;
      fcmd  = rx_sof ? rx_data[23:16] : fcmd_q;
   end

   // payload beats of a data frame go straight to the store
   assign ram_we    = acc && (ftype == FT_DATA) && (beat != '0);
   assign ram_waddr = AW'(wr_sector << SW) + AW'(beat - BEAT_W'(1));
   assign ram_wdata = rx_data;

   assign evt_lba = {lba_hi_q, lba_lo_q};
   assign evt_cnt = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q     <= '0;
         ftype_q    <= '0;
         fcmd_q     <= '0;
         lba_lo_q   <= '0;
         lba_hi_q   <= '0;
         cnt_q      <= '0;
         evt_wr_cmd <= 1'b0;
         evt_rd_cmd <= 1'b0;
         evt_data   <= 1'b0;
         evt_pend   <= 1'b0;
         evt_pay    <= '0;
      end else begin
         evt_wr_cmd <= 1'b0;
         evt_rd_cmd <= 1'b0;
         evt_data   <= 1'b0;
         evt_pend   <= 1'b0;
         if (acc) begin
            beat_q <= beat + BEAT_W'(1);
            if (rx_sof) begin
               ftype_q <= rx_data[7:0];
               fcmd_q  <= rx_data[23:16];
            end
            if (beat == BEAT_W'(1)) lba_lo_q <= rx_data;
            if (beat == BEAT_W'(2)) lba_hi_q <= rx_data[15:0];
            if (beat == BEAT_W'(3)) cnt_q    <= rx_data[CNT_W-1:0];
            if (rx_eof) begin
               evt_pend <= 1'b1;
               evt_pay  <= beat;
               if (ftype == FT_DATA)
                  evt_data <= 1'b1;
               else if (ftype == FT_REG_H2D && fcmd == CMD_WR_EXT)
                  evt_wr_cmd <= 1'b1;
               else if (ftype == FT_REG_H2D && fcmd == CMD_RD_EXT)
                  evt_rd_cmd <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dma_sector_ram.sv
module dma_sector_ram #(
   parameter int DW    = 32,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/dma_resp_ctrl.sv
module dma_resp_ctrl
   import dma_resp_pkg::*;
#(
   parameter int SECTOR_DW    = 128,
   parameter int MAX_FRAME_DW = 2048,
   parameter int RAM_SECTORS  = 8,
   parameter int BEAT_W       = 12,
   localparam int SW  = $clog2(SECTOR_DW),
   localparam int AW  = $clog2(SECTOR_DW * RAM_SECTORS),
   localparam int SPF = MAX_FRAME_DW / SECTOR_DW,
   localparam int CW  = $clog2(SPF + 1),
   localparam int PW  = $clog2(MAX_FRAME_DW + STAT_DW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_wr_cmd,
   input  logic              evt_rd_cmd,
   input  logic              evt_data,
   input  logic [LBA_W-1:0]  evt_lba,
   input  logic [CNT_W-1:0]  evt_cnt,
   input  logic [BEAT_W-1:0] evt_pay,
   input  logic [31:0]       ram_rdata,
   output logic [AW-1:0]     ram_raddr,
   output logic [LBA_W-1:0]  wr_sector,
   output logic              idle,
   output logic              tx_valid,
   output logic              tx_sof,
   output logic              tx_eof,
   output logic [31:0]       tx_data
);
   tx_state_e        st_q;
   logic [LBA_W-1:0] wr_sec_q, wr_end_q, rd_sec_q, rd_end_q;
   logic [LBA_W-1:0] remain, wr_next, rd_next;
   logic [PW-1:0]    idx_q, pay_len_q;
   logic [CW-1:0]    chunk_q, chunk;
   logic             pay_last, stat_last;

   always_comb begin
      remain  = rd_end_q - rd_sec_q;
      chunk   = (remain > LBA_W'(SPF)) ? CW'(SPF) : CW'(remain);
      wr_next = wr_sec_q + LBA_W'(evt_pay >> SW);
      rd_next = rd_sec_q + LBA_W'(chunk_q);
   end

   assign pay_last  = (idx_q == pay_len_q - PW'(1));
   assign stat_last = (idx_q == PW'(STAT_DW - 1));
   assign wr_sector = wr_sec_q;
   assign idle      = (st_q == TX_IDLE);

   // address one beat ahead of the output, store read has one cycle latency
   assign ram_raddr = AW'(rd_sec_q << SW) +
                      ((st_q == TX_DPAY) ? AW'(idx_q + PW'(1)) : AW'(0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= TX_IDLE;
         wr_sec_q  <= '0;
         wr_end_q  <= '0;
         rd_sec_q  <= '0;
         rd_end_q  <= '0;
         idx_q     <= '0;
         pay_len_q <= '0;
         chunk_q   <= '0;
      end else begin
         case (st_q)
            TX_IDLE: begin
               idx_q <= '0;
               if (evt_wr_cmd) begin
                  wr_sec_q <= evt_lba;
                  wr_end_q <= evt_lba + LBA_W'(evt_cnt);
                  st_q     <= TX_ACT;
               end else if (evt_data) begin
                  wr_sec_q <= wr_next;
                  st_q     <= (wr_next == wr_end_q) ? TX_STAT : TX_ACT;
               end else if (evt_rd_cmd) begin
                  rd_sec_q <= evt_lba;
                  rd_end_q <= evt_lba + LBA_W'(evt_cnt);
                  st_q     <= (evt_cnt == '0) ? TX_STAT : TX_DHDR;
               end
            end
            TX_ACT: st_q <= TX_IDLE;
            TX_STAT: begin
               idx_q <= idx_q + PW'(1);
               if (stat_last) begin
                  idx_q <= '0;
                  st_q  <= TX_IDLE;
               end
            end
            TX_DHDR: begin
               chunk_q   <= chunk;
               pay_len_q <= PW'(PW'(chunk) << SW);
               idx_q     <= '0;
               st_q      <= TX_DPAY;
            end
            TX_DPAY: begin
               idx_q <= idx_q + PW'(1);
               if (pay_last) begin
                  idx_q    <= '0;
                  rd_sec_q <= rd_next;
                  st_q     <= (rd_next == rd_end_q) ? TX_STAT : TX_DHDR;
               end
            end
            default: st_q <= TX_IDLE;
         endcase
      end
   end

   always_comb begin
      tx_valid = (st_q != TX_IDLE);
      tx_sof   = 1'b0;
      tx_eof   = 1'b0;
      tx_data  = '0;
      case (st_q)
         TX_ACT: begin
            tx_sof  = 1'b1;
            tx_eof  = 1'b1;
            tx_data = {24'h0, FT_DMA_ACT};
         end
         TX_STAT: begin
            tx_sof  = (idx_q == '0);
            tx_eof  = stat_last;
            tx_data = (idx_q == '0) ? {8'h0, STATUS_OK, 8'h0, FT_REG_D2H} : 32'h0;
         end
         TX_DHDR: begin
            tx_sof  = 1'b1;
            tx_data = {24'h0, FT_DATA};
         end
         TX_DPAY: begin
            tx_eof  = pay_last;
            tx_data = ram_rdata;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dma_cmd_responder.sv
module dma_cmd_responder
   import dma_resp_pkg::*;
#(
   parameter int SECTOR_DW    = 128,
   parameter int MAX_FRAME_DW = 2048,
   parameter int RAM_SECTORS  = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_valid,
   input  logic        rx_sof,
   input  logic        rx_eof,
   input  logic [31:0] rx_data,
   output logic        rx_ready,
   output logic        tx_valid,
   output logic        tx_sof,
   output logic        tx_eof,
   output logic [31:0] tx_data
);
   localparam int DEPTH  = SECTOR_DW * RAM_SECTORS;
   localparam int AW     = $clog2(DEPTH);
   localparam int BEAT_W = $clog2(MAX_FRAME_DW + 3);

   if (SECTOR_DW < 2 || (SECTOR_DW & (SECTOR_DW - 1)) != 0) begin : g_bad_sector
      $error("SECTOR_DW must be a power of two of at least 2");
   end
   if (RAM_SECTORS < 2 || (RAM_SECTORS & (RAM_SECTORS - 1)) != 0) begin : g_bad_ram
      $error("RAM_SECTORS must be a power of two of at least 2");
   end
   if (MAX_FRAME_DW < SECTOR_DW || (MAX_FRAME_DW % SECTOR_DW) != 0) begin : g_bad_frame
      $error("MAX_FRAME_DW must be a whole number of sectors");
   end

   logic              evt_wr_cmd, evt_rd_cmd, evt_data, evt_pend, ctrl_idle;
   logic [LBA_W-1:0]  evt_lba, wr_sector;
   logic [CNT_W-1:0]  evt_cnt;
   logic [BEAT_W-1:0] evt_pay;
   logic              ram_we;
   logic [AW-1:0]     ram_waddr, ram_raddr;
   logic [31:0]       ram_wdata, ram_rdata;

   assign rx_ready = ctrl_idle & ~evt_pend;

   dma_rx_decode #(
      .SECTOR_DW  (SECTOR_DW),
      .RAM_SECTORS(RAM_SECTORS),
      .BEAT_W     (BEAT_W)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_sof    (rx_sof),
      .rx_eof    (rx_eof),
      .rx_data   (rx_data),
      .rx_ready  (rx_ready),
      .wr_sector (wr_sector),
      .ram_we    (ram_we),
      .ram_waddr (ram_waddr),
      .ram_wdata (ram_wdata),
      .evt_wr_cmd(evt_wr_cmd),
      .evt_rd_cmd(evt_rd_cmd),
      .evt_data  (evt_data),
      .evt_pend  (evt_pend),
      .evt_lba   (evt_lba),
      .evt_cnt   (evt_cnt),
      .evt_pay   (evt_pay)
   );

   dma_sector_ram #(
      .DW   (32),
      .DEPTH(DEPTH)
   ) u_ram (
      .clk  (clk),
      .we   (ram_we),
      .waddr(ram_waddr),
      .wdata(ram_wdata),
      .raddr(ram_raddr),
      .rdata(ram_rdata)
   );

   dma_resp_ctrl #(
      .SECTOR_DW   (SECTOR_DW),
      .MAX_FRAME_DW(MAX_FRAME_DW),
      .RAM_SECTORS (RAM_SECTORS),
      .BEAT_W      (BEAT_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_wr_cmd(evt_wr_cmd),
      .evt_rd_cmd(evt_rd_cmd),
      .evt_data  (evt_data),
      .evt_lba   (evt_lba),
      .evt_cnt   (evt_cnt),
      .evt_pay   (evt_pay),
      .ram_rdata (ram_rdata),
      .ram_raddr (ram_raddr),
      .wr_sector (wr_sector),
      .idle      (ctrl_idle),
      .tx_valid  (tx_valid),
      .tx_sof    (tx_sof),
      .tx_eof    (tx_eof),
      .tx_data   (tx_data)
   );
endmodule

// File: rtl/dma_cmd_responder_chk.sv
module dma_cmd_responder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rx_valid,
   input logic        rx_ready,
   input logic        rx_eof,
   input logic        tx_valid,
   input logic        tx_sof,
   input logic        tx_eof,
   input logic [31:0] tx_data,
   input logic        evt_wr_cmd,
   input logic        evt_rd_cmd,
   input logic        evt_data
);
   assert_hold_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !rx_ready);

   assert_end_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ready && rx_eof) |=> !rx_ready);

   assert_act_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_wr_cmd |=> (tx_valid && tx_sof && tx_eof && tx_data == 32'h0000_0039));

   assert_data_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_data |=> (tx_valid && tx_sof &&
                    (tx_data[7:0] == 8'h39 || tx_data[7:0] == 8'h34)));

   assert_read_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_rd_cmd |=> (tx_valid && tx_sof &&
                      (tx_data[7:0] == 8'h46 || tx_data[7:0] == 8'h34)));

   assert_contiguous_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_eof) |=> (tx_valid && !tx_sof));
endmodule

bind dma_cmd_responder dma_cmd_responder_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .rx_eof    (rx_eof),
   .tx_valid  (tx_valid),
   .tx_sof    (tx_sof),
   .tx_eof    (tx_eof),
   .tx_data   (tx_data),
   .evt_wr_cmd(evt_wr_cmd),
   .evt_rd_cmd(evt_rd_cmd),
   .evt_data  (evt_data)
);

// File: tb/dma_cmd_responder_bench.sv
`timescale 1ns/1ps
module dma_cmd_responder_bench;
   localparam int SDW   = 4;
   localparam int MFD   = 8;
   localparam int RS    = 16;
   localparam int DEPTH = SDW * RS;
   localparam int SPF   = MFD / SDW;
   localparam longint MASK = (64'sd1 <<< 48) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic [31:0] rx_data = '0;
   logic        rx_ready, tx_valid, tx_sof, tx_eof;
   logic [31:0] tx_data;

   dma_cmd_responder #(
      .SECTOR_DW(SDW), .MAX_FRAME_DW(MFD), .RAM_SECTORS(RS)
   ) u_dma_cmd_responder (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_eof(rx_eof), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_data(tx_data)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int nvec = 0, nerr = 0;
   logic [31:0] fr [16];
   logic [31:0] bmem [DEPTH];
   logic [31:0] od [256];
   logic        osof [256], oeof [256];
   int          on = 0;
   logic [31:0] ed [256];
   logic        esof [256], eeof [256];
   int          en = 0;
   int          first_tx = -1, t_eof = 0, gap_err = 0, ready_err = 0;
   logic        inframe = 1'b0;
   longint      wsec = 0, wend = 0;
   int          seed = 1;

   // output monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid) begin
            if (rx_ready) ready_err++;
            if (on == 0) first_tx = cyc;
            if (on < 256) begin
               od[on] = tx_data; osof[on] = tx_sof; oeof[on] = tx_eof;
            end
            on++;
            if (tx_sof == inframe) gap_err++;
            inframe = !tx_eof;
         end else if (inframe) begin
            gap_err++;
            inframe = 1'b0;
         end
      end
   end

   task automatic send(input int n);
      on = 0; en = 0; first_tx = -1;
      for (int i = 0; i < n; i++) begin
         rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1); rx_data = fr[i];
         @(negedge clk);
         while (!rx_ready) @(negedge clk);
         @(posedge clk); #1;
      end
      t_eof = cyc;
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
   endtask

   task automatic settle();
      int q = 0;
      while (q < 4) begin
         @(negedge clk);
         if (!tx_valid && rx_ready) q++; else q = 0;
      end
   endtask

   task automatic push(input logic [31:0] d, input logic s, input logic e);
      if (en < 256) begin ed[en] = d; esof[en] = s; eeof[en] = e; end
      en++;
   endtask

   task automatic exp_act();
      push(32'h0000_0039, 1'b1, 1'b1);
   endtask

   task automatic exp_stat();
      push(32'h0050_0034, 1'b1, 1'b0);
      for (int i = 1; i < 5; i++) push(32'h0, 1'b0, i == 4);
   endtask

   task automatic exp_read(input longint lba, input int cnt);
      longint rs, re, rem;
      int ch;
      rs = lba & MASK;
      re = (lba + cnt) & MASK;
      while (rs != re) begin
         rem = (re - rs) & MASK;
         ch = (rem > SPF) ? SPF : int'(rem);
         push(32'h0000_0046, 1'b1, 1'b0);
         for (int j = 0; j < ch * SDW; j++)
            push(bmem[int'((rs * SDW + j) % DEPTH)], 1'b0, j == ch * SDW - 1);
         rs = (rs + ch) & MASK;
      end
      exp_stat();
   endtask

   task automatic compare(input string req);
      nvec++;
      if (on != en) begin
         nerr++;
         $display("FAIL %s: frame beats actual %0d expected %0d", req, on, en);
      end else begin
         for (int i = 0; i < on; i++) begin
            if (od[i] !== ed[i] || osof[i] !== esof[i] || oeof[i] !== eeof[i]) begin
               nerr++;
               $display("FAIL %s: beat %0d actual %h/%b/%b expected %h/%b/%b",
                        req, i, od[i], osof[i], oeof[i], ed[i], esof[i], eeof[i]);
               break;
            end
         end
      end
   endtask

   task automatic check_latency(input string req);
      nvec++;
      if (first_tx != t_eof + 1) begin
         nerr++;
         $display("FAIL %s: first reply cycle actual %0d expected %0d", req, first_tx, t_eof + 1);
      end
   endtask

   task automatic build_cmd(input logic [7:0] ftype, input logic [7:0] cmd,
                            input longint lba, input int cnt);
      fr[0] = {8'h0, cmd, 8'h0, ftype};
      fr[1] = lba[31:0];
      fr[2] = {16'h0, lba[47:32]};
      fr[3] = {16'h0, cnt[15:0]};
      fr[4] = 32'h0;
   endtask

   // R3: write command opens the window and is answered by DMA-activate
   task automatic do_wcmd(input longint lba, input int cnt);
      build_cmd(8'h27, 8'h35, lba, cnt);
      wsec = lba & MASK;
      wend = (lba + cnt) & MASK;
      send(5); settle();
      exp_act();
      compare("R3");
      check_latency("R9");
   endtask

   // R5 R6: data frame stored at the write sector, reply depends on window end
   task automatic do_data(input int ndw);
      fr[0] = 32'h0000_0046;
      for (int i = 0; i < ndw; i++) begin
         fr[i + 1] = {seed[15:0], 16'(i)};
         bmem[int'((wsec * SDW + i) % DEPTH)] = fr[i + 1];
      end
      seed++;
      wsec = (wsec + ndw / SDW) & MASK;
      send(ndw + 1); settle();
      if (wsec == wend) exp_stat(); else exp_act();
      compare("R5 R6");
   endtask

   // R8: read window split into bounded data frames then status
   task automatic do_read(input longint lba, input int cnt);
      build_cmd(8'h27, 8'h25, lba, cnt);
      send(5); settle();
      exp_read(lba, cnt);
      compare(cnt == 0 ? "R7 R8" : "R8");
      check_latency("R9");
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) bmem[i] = 32'h0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state at the ports
      nvec++;
      if (tx_valid !== 1'b0 || rx_ready !== 1'b1) begin
         nerr++;
         $display("FAIL R10: tx_valid/rx_ready actual %b/%b expected 0/1", tx_valid, rx_ready);
      end
      // R10: data before any command lands in sector 0, window end 0 -> activate
      wsec = 0; wend = 0;
      do_data(SDW);
      do_read(0, 1);

      // fill the whole store, two sectors per frame; last reply is status (R7)
      do_wcmd(0, RS);
      for (int k = 0; k < RS / SPF; k++) do_data(MFD);

      // R2: unknown type is ignored, including a read-shaped frame of wrong type
      fr[0] = 32'h0000_005A; fr[1] = 32'hDEAD_BEEF; fr[2] = 32'h1234_5678;
      send(3); settle(); compare("R2");
      build_cmd(8'h28, 8'h25, 0, 2);
      send(5); settle(); compare("R2");
      // R4: unsupported command byte
      build_cmd(8'h27, 8'h60, 0, 2);
      send(5); settle(); compare("R4");

      // R5: payload not a whole number of sectors, then overwrite
      do_wcmd(10, 2);
      do_data(6);
      do_data(4);
      // R5: write across the end of the store
      do_wcmd(15, 2);
      do_data(MFD);
      // R3: upper address field in use
      do_wcmd((64'sd1 <<< 32) + 5, 1);
      do_data(SDW);
      // R6: window opened with a count of zero never closes on data
      do_wcmd(3, 0);
      do_data(SDW);
      do_wcmd(3, 1);
      do_data(SDW);

      // R8: sweep of read windows over the whole store, including wrap
      for (int lba = 0; lba < RS; lba++)
         for (int cnt = 0; cnt <= 5; cnt++)
            do_read(lba, cnt);
      do_read((64'sd1 <<< 32) + 14, 4);

      // R1 R9: port-level framing and hold-off over the whole run
      nvec++;
      if (ready_err != 0) begin
         nerr++;
         $display("FAIL R1: rx_ready during reply actual %0d cycles expected 0", ready_err);
      end
      nvec++;
      if (gap_err != 0) begin
         nerr++;
         $display("FAIL R9: framing gaps actual %0d expected 0", gap_err);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      #(200000 * 10);
      nvec++; nerr++;
      $display("FAIL watchdog: run not finished, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule